// File: doc/BRIEF.md
# Per-Pin Selectable Interrupt Sense Unit

The block watches four interrupt pins and turns activity on each one into an interrupt request. Each pin has its own two-bit sense code. The code picks one of four modes: a held low level, any change, a falling edge or a rising edge. Edge modes pass the pin through a two-flop synchronizer. A detected edge sets a sticky flag, and that flag holds until software pulses the pin's clear strobe.

Edge detection runs only while the I/O clock indicator is high. Low-level mode is purely combinational and needs no clock. An enabled pin held low in low-level mode raises `wake_o` at once, even with the clock stopped, so the system can leave a deep sleep state. That same pin raises its interrupt request only after `startup_done_i` is high. If the level goes away before start-up ends, the system has still been woken, but no request is seen.

A pin configured as an output on the chip still reaches this block. Writing to such a pin therefore raises a request, which gives software a way to trigger an interrupt.

Top module: `ext_irq_sense`

## Requirements
- R1: After reset, with every pin high and every flag clear, `irq_o` is 0 and `wake_o` is 0.
- R2: With sense code 2'b10 (falling edge) and the pin enabled, a 1-to-0 pin change sets the pin's request on the third rising clock edge after the change. A 0-to-1 change sets nothing.
- R3: With sense code 2'b11 (rising edge) and the pin enabled, a 0-to-1 change sets the request on the third rising edge after the change. A 1-to-0 change sets nothing.
- R4: With sense code 2'b01 (any change) and the pin enabled, either direction of change sets the request on the third rising edge.
- R5: An edge-mode request stays set until its bit of `clr_i` is high at a rising edge, and it drops after that edge. If a new edge arrives in the same cycle as the clear, the set wins.
- R6: A pin whose enable bit is 0 never sets its flag, and in low-level mode its request stays 0.
- R7: With sense code 2'b00 (low level), the pin's request is `en & ~pin & startup_done_i`. It follows the inputs without waiting for a clock edge, and it clears any stored edge flag at the next rising edge.
- R8: `wake_o` is high while any enabled pin in low-level mode is low, whatever the values of `startup_done_i` and `clk_run_i`.
- R9: While `clk_run_i` is 0, no edge is recognised. A pin change made while the clock is stopped does not set a flag after the clock resumes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | I/O clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pin_i | input | N | Raw interrupt pins |
| mode_i | input | 2*N | Sense code per pin; pin i uses bits [2i+1:2i] |
| en_i | input | N | Per-pin enable |
| clk_run_i | input | 1 | High while the I/O clock is treated as running |
| clr_i | input | N | Per-pin flag clear strobe |
| startup_done_i | input | 1 | High once oscillator start-up has finished |
| irq_o | output | N | Per-pin interrupt request |
| wake_o | output | 1 | Asynchronous wake request from low-level pins |

## Verification
The hardest situation to reach is a pin that changes while the clock is stopped, followed by the clock resuming. A naive design would treat that stale difference as a fresh edge. The bench stops the clock indicator, toggles pins, holds the new value across several cycles, restarts the clock, and confirms that no flag appears. The random phase also drops `clk_run_i` now and then, while modes, enables and clears change under it. This lets stoppages land in the middle of a synchronizer transit and on top of a pending clear.

// File: rtl/ext_irq_sense.sv
module ext_irq_sense #(
  parameter int N = 4
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [N-1:0]   pin_i,
  input  logic [2*N-1:0] mode_i,
  input  logic [N-1:0]   en_i,
  input  logic           clk_run_i,
  input  logic [N-1:0]   clr_i,
  input  logic           startup_done_i,
  output logic [N-1:0]   irq_o,
  output logic           wake_o
);

  localparam logic [1:0] SENSE_LOW  = 2'b00;
  localparam logic [1:0] SENSE_ANY  = 2'b01;
  localparam logic [1:0] SENSE_FALL = 2'b10;

  logic [N-1:0] s1, s2, prev, flag, lvl, hit, lvl_req;

  for (genvar i = 0; i < N; i++) begin : g_pin
    logic [1:0] m;
    assign m = mode_i[2*i +: 2];
    assign lvl[i] = (m == SENSE_LOW);
    assign lvl_req[i] = en_i[i] & ~pin_i[i];
    always_comb begin
      if (!en_i[i] || lvl[i] || !clk_run_i) hit[i] = 1'b0;
      else if (m == SENSE_ANY)              hit[i] = s2[i] ^ prev[i];
      else if (m == SENSE_FALL)             hit[i] = prev[i] & ~s2[i];
      else                                  hit[i] = ~prev[i] & s2[i];
    end
    assign irq_o[i] = lvl[i] ? (lvl_req[i] & startup_done_i) : flag[i];

    assert_flag_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (flag[i] && !clr_i[i] && !lvl[i]) |=> flag[i]);
    assert_no_set_disabled_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (!en_i[i] && !flag[i]) |=> !flag[i]);
    assert_set_needs_clock_R9: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(flag[i]) |-> $past(clk_run_i));
    assert_level_high_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (lvl[i] && pin_i[i]) |-> !irq_o[i]);
    assert_level_clears_flag_R7: assert property (@(posedge clk) disable iff (!rst_n)
      lvl[i] |=> (!flag[i] || !$past(lvl[i]) || $past(hit[i])));
    assert_level_wakes_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (lvl[i] && en_i[i] && !pin_i[i]) |-> wake_o);
  end

  assign wake_o = |(lvl & lvl_req);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1   <= '1;
      s2   <= '1;
      prev <= '1;
      flag <= '0;
    end else if (!clk_run_i) begin
      s1   <= pin_i;
      s2   <= pin_i;
      prev <= pin_i;
      flag <= flag & ~clr_i & ~lvl;
    end else begin
      s1   <= pin_i;
      s2   <= s1;
      prev <= s2;
      flag <= (flag & ~clr_i & ~lvl) | hit;
    end
  end

  assert_stopped_stable_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!clk_run_i && clr_i == '0 && lvl == '0) |=> $stable(flag));

endmodule

// File: tb/sim_ext_irq_sense.sv
module sim_ext_irq_sense;
  localparam int N = 4;
  localparam int CLK_PERIOD = 10;

  logic clk = 0, rst_n = 0;
  logic [N-1:0] pin = '1, en = '0, clr = '0;
  logic [2*N-1:0] mode = '0;
  logic run = 1, sud = 0;
  logic [N-1:0] irq;
  logic wake;

  int vectors = 0, errors = 0;
  bit done = 0;

  ext_irq_sense #(.N(N)) u0 (
    .clk(clk), .rst_n(rst_n), .pin_i(pin), .mode_i(mode), .en_i(en),
    .clk_run_i(run), .clr_i(clr), .startup_done_i(sud),
    .irq_o(irq), .wake_o(wake));

  always #(CLK_PERIOD/2) clk = ~clk;

  // bench reference pipeline, built from the requirement timing
  logic [N-1:0] r_a = '1, r_b = '1, r_c = '1, r_f = '0;

  function automatic logic edge_seen(logic [1:0] m, logic old, logic cur);
    case (m)
      2'b01:   return old != cur;
      2'b10:   return old && !cur;
      2'b11:   return !old && cur;
      default: return 1'b0;
    endcase
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      r_a <= '1; r_b <= '1; r_c <= '1; r_f <= '0;
    end else begin
      for (int i = 0; i < N; i++) begin
        logic lv;
        lv = mode[2*i +: 2] == 2'b00;
        if (run && en[i] && edge_seen(mode[2*i +: 2], r_c[i], r_b[i])) r_f[i] <= 1'b1;
        else if (clr[i] || lv) r_f[i] <= 1'b0;
      end
      if (run) begin r_a <= pin; r_b <= r_a; r_c <= r_b; end
      else     begin r_a <= pin; r_b <= pin; r_c <= pin; end
    end
  end

  function automatic logic [N-1:0] want_irq();
    logic [N-1:0] v;
    for (int i = 0; i < N; i++)
      v[i] = (mode[2*i +: 2] == 2'b00) ? (en[i] & ~pin[i] & sud) : r_f[i];
    return v;
  endfunction

  function automatic logic want_wake();
    logic w = 0;
    for (int i = 0; i < N; i++)
      if (mode[2*i +: 2] == 2'b00 && en[i] && !pin[i]) w = 1;
    return w;
  endfunction

  task automatic check(string tag, logic [N-1:0] ei, logic ew);
    vectors++;
    if (irq !== ei || wake !== ew) begin
      errors++;
      $display("FAIL %s: irq=%b wake=%b expected irq=%b wake=%b", tag, irq, wake, ei, ew);
    end
  endtask

  task automatic step(string tag);
    @(posedge clk);
    #2;
    check(tag, want_irq(), want_wake());
    #1;
  endtask

  initial begin
    #(CLK_PERIOD*20000);
    errors++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed));
    mode = {N{2'b10}};
    #(CLK_PERIOD*3 + 3);
    rst_n = 1;
    #1;
    check("R1 reset state", '0, 0);
    step("R1 idle");

    // R2 falling edge, pin 0
    en = 4'b0001; sud = 1;
    pin[0] = 0;
    step("R2 t1"); check("R2 not yet", '0, 0);
    step("R2 t2"); check("R2 not yet", '0, 0);
    step("R2 t3"); check("R2 falling sets", 4'b0001, 0);
    pin[0] = 1;
    repeat (4) step("R2 rise ignored");
    check("R2 rise no effect", 4'b0001, 0);
    // R5 clear
    clr = 4'b0001; step("R5 clear"); clr = 0;
    check("R5 cleared", '0, 0);
    // R3 rising, pin 1
    mode[3:2] = 2'b11; en = 4'b0010;
    pin[1] = 0; repeat (4) step("R3 fall ignored");
    check("R3 no fall", '0, 0);
    pin[1] = 1; step("R3 t1"); step("R3 t2"); step("R3 t3");
    check("R3 rising sets", 4'b0010, 0);
    // R5 set beats clear: pending edge coincides with clear
    pin[1] = 0; step("R5 a"); pin[1] = 1; step("R5 b"); step("R5 c");
    clr = 4'b0010; step("R5 set wins"); clr = 0;
    check("R5 set over clear", 4'b0010, 0);
    clr = 4'b0010; step("R5 clr"); clr = 0;
    // R4 any change, pin 2
    mode[5:4] = 2'b01; en = 4'b0100;
    pin[2] = 0; repeat (3) step("R4 fall");
    check("R4 fall sets", 4'b0100, 0);
    clr = 4'b0100; step("R4 clr"); clr = 0;
    pin[2] = 1; repeat (3) step("R4 rise");
    check("R4 rise sets", 4'b0100, 0);
    clr = 4'b0100; step("R4 clr2"); clr = 0;
    // R6 disabled pin
    en = 0; pin[3] = 0; repeat (4) step("R6 disabled");
    check("R6 no flag", '0, 0);
    mode[7:6] = 2'b00; #1; check("R6 level disabled", '0, 0);
    // R7 / R8 level mode, no clock needed
    en[3] = 1; sud = 0; #1;
    check("R8 wake before startup", '0, 1);
    check("R7 gated by startup", '0, 1);
    run = 0; sud = 1; #1;
    check("R7 level async", 4'b1000, 1);
    pin[3] = 1; #1;
    check("R7 level gone", '0, 0);
    run = 1; step("R7 settle");
    // R7 level mode clears stored flag
    mode[1:0] = 2'b10; en = 4'b1001; pin[0] = 0;
    repeat (3) step("R7 setup"); pin[0] = 1;
    mode[1:0] = 2'b00; step("R7 flag wiped");
    mode[1:0] = 2'b10; #1;
    check("R7 stored flag cleared", '0, 0);
    // R9 changes while stopped are ignored on resume
    mode = {N{2'b01}}; en = '1; step("R9 prep");
    run = 0; pin = 4'b0101; repeat (3) step("R9 stopped");
    check("R9 none while stopped", '0, 0);
    run = 1; repeat (4) step("R9 resumed");
    check("R9 none after resume", '0, 0);
    clr = '1; step("R9 clr"); clr = 0;

    // constrained random phase
    for (int k = 0; k < 4000; k++) begin
      if ($urandom_range(0, 9) == 0) pin[$urandom_range(0, N-1)] ^= 1'b1;
      if ($urandom_range(0, 49) == 0) mode = $urandom;
      if ($urandom_range(0, 29) == 0) en = $urandom;
      run = $urandom_range(0, 9) != 0;
      clr = ($urandom_range(0, 5) == 0) ? N'($urandom) : '0;
      sud = $urandom_range(0, 3) != 0;
      step("R2-R9 random");
    end

    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule